// File: doc/BRIEF.md
# Stepper Driver Fault and Power-State Supervisor

This block decides when the two output bridges of a stepper driver may conduct. It takes the output-disable input, the sleep and translator-reset inputs, and three protection flags from the analog sensing circuits (overcurrent, over-temperature and supply undervoltage). All of these arrive already synchronous to the block clock. From them it produces a bridge enable, a request that sends the step translator to its Home position, a gated step strobe for the translator, and the enable of an open-drain pad that pulls the fault line low.

Overcurrent is the only fault that is remembered and reported. It is held until the part is put to sleep, the translator is reset, or the supply drops below its lockout threshold. Over-temperature and undervoltage only hold the bridges off while the flag is present, and they leave the fault line alone. The output-disable input turns off the bridges but leaves the step path running, so the motor position keeps tracking commands.

On every wake from sleep, including the first cycle after system reset, a settle timer runs for a time set by parameters. It is one millisecond by default at the default clock frequency. While the timer runs, step commands are dropped and a busy flag is raised.

Top module: `drv_supervisor`

## Requirements
- R1: A cycle with `ocp_flag` high and no clear condition (R2) sets the overcurrent latch. From the next cycle `fault_pull_lo` is 1 and `bridge_en` is 0, and both stay so after `ocp_flag` falls, until a clear condition occurs.
- R2: `sleep_n` low, `xlat_rst_n` low or `uvlo_flag` high in a cycle clears the overcurrent latch, so `fault_pull_lo` is 0 in the next cycle. When a clear condition and `ocp_flag` are in the same cycle, the clear wins.
- R3: While `tsd_flag` is 1, `bridge_en` is 0 in the same cycle. When the flag falls, `bridge_en` returns with no other action. `tsd_flag` never sets `fault_pull_lo`.
- R4: While `uvlo_flag` is 1, `bridge_en` is 0, `home_req` is 1 and `step_out` is 0, all in the same cycle. `uvlo_flag` never sets `fault_pull_lo`.
- R5: While `out_off` is 1, `bridge_en` is 0, but `step_in` still reaches `step_out` in the same cycle.
- R6: While `sleep_n` is 0, `bridge_en` is 0, `home_req` is 1 and `step_out` is 0.
- R7: A wake happens when a clock edge samples `sleep_n` high and the previous sample was low. The sample before the first edge after `rst_n` release counts as low. After a wake, `settle_busy` is 1 for exactly SETTLE = ceil(CLK_HZ*SETTLE_US/1e6) cycles, starting on the next cycle. During those cycles `step_out` is 0.
- R8: While `xlat_rst_n` is 0, `bridge_en` is 0, `home_req` is 1 and `step_out` is 0.
- R9: In the idle state (awake, settled, no fault, all inputs inactive), `bridge_en` is 1, `home_req` is 0 and `step_out` equals `step_in` in the same cycle.
- R10: While `rst_n` is 0, `fault_pull_lo` and `settle_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| out_off | input | 1 | Output disable: 1 turns the bridges off |
| sleep_n | input | 1 | 0 puts the driver to sleep |
| xlat_rst_n | input | 1 | Translator reset, active low |
| ocp_flag | input | 1 | Overcurrent detected (synchronous) |
| tsd_flag | input | 1 | Over-temperature detected (synchronous) |
| uvlo_flag | input | 1 | Supply undervoltage detected (synchronous) |
| step_in | input | 1 | Step strobe from the controller |
| bridge_en | output | 1 | Bridges may conduct |
| home_req | output | 1 | Translator must go to Home |
| step_out | output | 1 | Gated step strobe to the translator |
| settle_busy | output | 1 | Wake settle timer is running |
| fault_pull_lo | output | 1 | Enable for the open-drain fault pad (1 pulls low) |

## Verification
Two pairs of events can land in the same cycle. The first pair is setting and clearing the overcurrent latch. The bench raises `ocp_flag` in the very cycle where translator reset goes low, and then where `uvlo_flag` goes high. The next cycle must show `fault_pull_lo` at 0. The second pair is the end of the settle window and a step. The bench holds `step_in` high through a wake, counts the cycles in which `settle_busy` is 1 while `step_out` stays 0, and expects `step_out` to follow on the first cycle after the busy flag drops.

// File: rtl/sup_pkg.sv
package sup_pkg;
  // number of clock cycles in a settle window, rounded up
  function automatic longint unsigned settle_cycles(longint unsigned clk_hz,
                                                    longint unsigned us);
    return (clk_hz * us + 64'd999_999) / 64'd1_000_000;
  endfunction
endpackage

// File: rtl/sup_ocp_latch.sv
module sup_ocp_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
  end
endmodule

// File: rtl/sup_settle_timer.sv
module sup_settle_timer #(
  parameter longint unsigned CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic awake_i,
  output logic wake_evt_o,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic          awake_q;
  logic [CW-1:0] cnt;

  assign wake_evt_o = awake_i && !awake_q;
  assign busy_o     = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      awake_q <= 1'b0;
      cnt     <= '0;
    end else begin
      awake_q <= awake_i;
      if (!awake_i)        cnt <= '0;
      else if (wake_evt_o) cnt <= LOAD;
      else if (busy_o)     cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/sup_out_gate.sv
module sup_out_gate (
  input  logic out_off_i,
  input  logic sleep_n_i,
  input  logic xlat_rst_n_i,
  input  logic tsd_i,
  input  logic uvlo_i,
  input  logic ocp_lat_i,
  input  logic busy_i,
  input  logic step_i,
  output logic bridge_en_o,
  output logic home_o,
  output logic step_o
);
  logic seq_ok;
  always_comb begin
    seq_ok      = sleep_n_i && xlat_rst_n_i && !uvlo_i;
    home_o      = !seq_ok;
    bridge_en_o = seq_ok && !out_off_i && !tsd_i && !ocp_lat_i;
    step_o      = step_i && seq_ok && !busy_i;
  end
endmodule

// File: rtl/drv_supervisor.sv
module drv_supervisor #(
  parameter longint unsigned CLK_HZ    = 50_000_000,
  parameter longint unsigned SETTLE_US = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic out_off,
  input  logic sleep_n,
  input  logic xlat_rst_n,
  input  logic ocp_flag,
  input  logic tsd_flag,
  input  logic uvlo_flag,
  input  logic step_in,
  output logic bridge_en,
  output logic home_req,
  output logic step_out,
  output logic settle_busy,
  output logic fault_pull_lo
);
  localparam longint unsigned SETTLE = sup_pkg::settle_cycles(CLK_HZ, SETTLE_US);

  // named internal events
  logic ocp_set, ocp_clr, ocp_lat, wake_evt;

  assign ocp_clr = !sleep_n || !xlat_rst_n || uvlo_flag;
  assign ocp_set = ocp_flag;

  sup_ocp_latch u_latch (
    .clk(clk), .rst_n(rst_n), .set_i(ocp_set), .clr_i(ocp_clr), .q_o(ocp_lat)
  );

  sup_settle_timer #(.CYCLES(SETTLE)) u_timer (
    .clk(clk), .rst_n(rst_n), .awake_i(sleep_n),
    .wake_evt_o(wake_evt), .busy_o(settle_busy)
  );

  sup_out_gate u_gate (
    .out_off_i(out_off), .sleep_n_i(sleep_n), .xlat_rst_n_i(xlat_rst_n),
    .tsd_i(tsd_flag), .uvlo_i(uvlo_flag), .ocp_lat_i(ocp_lat),
    .busy_i(settle_busy), .step_i(step_in),
    .bridge_en_o(bridge_en), .home_o(home_req), .step_o(step_out)
  );

  assign fault_pull_lo = ocp_lat;
endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
  parameter longint unsigned SETTLE = 50000
) (
  input logic clk,
  input logic rst_n,
  input logic out_off,
  input logic sleep_n,
  input logic xlat_rst_n,
  input logic ocp_flag,
  input logic tsd_flag,
  input logic uvlo_flag,
  input logic bridge_en,
  input logic home_req,
  input logic step_out,
  input logic settle_busy,
  input logic fault_pull_lo,
  input logic wake_evt
);
  logic [63:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run <= '0;
    else if (settle_busy) run <= run + 1;
    else                  run <= '0;
  end

  a_r1_set: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_flag && sleep_n && xlat_rst_n && !uvlo_flag |=> fault_pull_lo);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pull_lo && sleep_n && xlat_rst_n && !uvlo_flag |=> fault_pull_lo);
  a_r1_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pull_lo |-> !bridge_en);
  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n || !xlat_rst_n || uvlo_flag |=> !fault_pull_lo);
  a_r3_tsd: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_flag |-> !bridge_en);
  a_r4_uvlo: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_flag |-> !bridge_en && home_req && !step_out);
  a_r5_off: assert property (@(posedge clk) disable iff (!rst_n)
    out_off |-> !bridge_en);
  a_r6_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |-> !bridge_en && home_req && !step_out);
  a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> settle_busy);
  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    settle_busy |-> !step_out);
  a_r7_len: assert property (@(posedge clk) disable iff (!rst_n)
    run <= SETTLE);
  a_r8_xrst: assert property (@(posedge clk) disable iff (!rst_n)
    !xlat_rst_n |-> !bridge_en && home_req && !step_out);
  always @(negedge clk)
    if (!rst_n) a_r10_reset: assert (!fault_pull_lo && !settle_busy);
endmodule

bind drv_supervisor sup_checker #(.SETTLE(SETTLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_off(out_off), .sleep_n(sleep_n),
  .xlat_rst_n(xlat_rst_n), .ocp_flag(ocp_flag), .tsd_flag(tsd_flag),
  .uvlo_flag(uvlo_flag), .bridge_en(bridge_en), .home_req(home_req),
  .step_out(step_out), .settle_busy(settle_busy),
  .fault_pull_lo(fault_pull_lo), .wake_evt(wake_evt)
);

// File: tb/test_drv_supervisor.sv
module test_drv_supervisor;
  localparam longint unsigned CLK_HZ = 50_000_000;
  localparam longint unsigned SET_US = 2;
  localparam int EXP_SETTLE = 100; // 50 cycles per microsecond * 2

  logic clk = 0, rst_n = 0;
  logic out_off = 0, sleep_n = 1, xlat_rst_n = 1;
  logic ocp_flag = 0, tsd_flag = 0, uvlo_flag = 0, step_in = 0;
  logic bridge_en, home_req, step_out, settle_busy, fault_pull_lo;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  drv_supervisor #(.CLK_HZ(CLK_HZ), .SETTLE_US(SET_US)) i_drv_supervisor (
    .clk(clk), .rst_n(rst_n), .out_off(out_off), .sleep_n(sleep_n),
    .xlat_rst_n(xlat_rst_n), .ocp_flag(ocp_flag), .tsd_flag(tsd_flag),
    .uvlo_flag(uvlo_flag), .step_in(step_in), .bridge_en(bridge_en),
    .home_req(home_req), .step_out(step_out), .settle_busy(settle_busy),
    .fault_pull_lo(fault_pull_lo)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic settle_comb(); #1; endtask

  // idle outputs, checked in one go
  task automatic chk_outs(string req, int be, int hr, int so, int fp);
    chk(req, "bridge_en", bridge_en, be);
    chk(req, "home_req", home_req, hr);
    chk(req, "step_out", step_out, so);
    chk(req, "fault_pull_lo", fault_pull_lo, fp);
  endtask

  // wake from sleep and count the busy window with a step held high
  task automatic wake_and_count(string req);
    int n = 0;
    step_in = 1;
    sleep_n = 1;
    tick();
    while (settle_busy && n < 10*EXP_SETTLE) begin
      if (step_out) chk(req, "step blocked while busy", 1, 0);
      n++;
      tick();
    end
    chk(req, "settle length", n, EXP_SETTLE);
    settle_comb();
    chk(req, "step passes after settle", step_out, 1);
    step_in = 0;
  endtask

  task automatic set_ocp();
    ocp_flag = 1; tick(); ocp_flag = 0;
  endtask

  task automatic t_reset();
    tick();
    chk("R10", "fault in reset", fault_pull_lo, 0);
    chk("R10", "busy in reset", settle_busy, 0);
    rst_n = 1;
    wake_and_count("R7");  // power-on counts as a wake
  endtask

  task automatic t_idle();
    step_in = 1; settle_comb();
    chk_outs("R9", 1, 0, 1, 0);
    step_in = 0; settle_comb();
    chk("R9", "step low", step_out, 0);
  endtask

  task automatic t_ocp_latch();
    ocp_flag = 1; settle_comb();
    chk("R1", "not yet set", fault_pull_lo, 0);
    tick(); ocp_flag = 0;
    chk("R1", "fault set", fault_pull_lo, 1);
    chk("R1", "bridge off", bridge_en, 0);
    repeat (3) tick();
    chk("R1", "fault held", fault_pull_lo, 1);
    chk("R1", "bridge held off", bridge_en, 0);
  endtask

  task automatic t_clear_xrst();
    xlat_rst_n = 0; tick(); xlat_rst_n = 1; settle_comb();
    chk("R2", "cleared by translator reset", fault_pull_lo, 0);
    chk("R2", "bridge back", bridge_en, 1);
  endtask

  task automatic t_clear_uvlo();
    set_ocp();
    chk("R1", "set again", fault_pull_lo, 1);
    uvlo_flag = 1; tick(); uvlo_flag = 0; settle_comb();
    chk("R2", "cleared by uvlo", fault_pull_lo, 0);
  endtask

  task automatic t_clear_sleep();
    set_ocp();
    sleep_n = 0; tick();
    chk("R2", "cleared by sleep", fault_pull_lo, 0);
    wake_and_count("R7");
    chk("R2", "stays clear after wake", fault_pull_lo, 0);
  endtask

  task automatic t_clear_wins();
    ocp_flag = 1; xlat_rst_n = 0; tick();
    ocp_flag = 0; xlat_rst_n = 1; settle_comb();
    chk("R2", "clear beats set (xlat reset)", fault_pull_lo, 0);
    ocp_flag = 1; uvlo_flag = 1; tick();
    ocp_flag = 0; uvlo_flag = 0; settle_comb();
    chk("R2", "clear beats set (uvlo)", fault_pull_lo, 0);
    tick();
    chk("R2", "still clear", fault_pull_lo, 0);
  endtask

  task automatic t_tsd();
    tsd_flag = 1; step_in = 1; settle_comb();
    chk("R3", "bridge off in tsd", bridge_en, 0);
    tick();
    chk("R3", "no fault from tsd", fault_pull_lo, 0);
    tsd_flag = 0; settle_comb();
    chk("R3", "bridge back after tsd", bridge_en, 1);
    step_in = 0;
  endtask

  task automatic t_uvlo();
    uvlo_flag = 1; step_in = 1; settle_comb();
    chk("R4", "bridge", bridge_en, 0);
    chk("R4", "home", home_req, 1);
    chk("R4", "step blocked", step_out, 0);
    tick();
    chk("R4", "no fault from uvlo", fault_pull_lo, 0);
    uvlo_flag = 0; settle_comb();
    chk_outs("R4", 1, 0, 1, 0);
    step_in = 0;
  endtask

  task automatic t_out_off();
    out_off = 1; step_in = 1; settle_comb();
    chk("R5", "bridge off", bridge_en, 0);
    chk("R5", "step still passes", step_out, 1);
    chk("R5", "no home", home_req, 0);
    out_off = 0; step_in = 0; settle_comb();
    chk("R5", "bridge back", bridge_en, 1);
  endtask

  task automatic t_sleep();
    sleep_n = 0; step_in = 1; settle_comb();
    chk("R6", "bridge", bridge_en, 0);
    chk("R6", "home", home_req, 1);
    chk("R6", "step blocked", step_out, 0);
    tick(); tick();
    chk("R6", "no busy while asleep", settle_busy, 0);
    wake_and_count("R7");
  endtask

  task automatic t_xrst();
    xlat_rst_n = 0; step_in = 1; settle_comb();
    chk("R8", "bridge", bridge_en, 0);
    chk("R8", "home", home_req, 1);
    chk("R8", "step ignored", step_out, 0);
    xlat_rst_n = 1; step_in = 0; settle_comb();
    chk("R8", "home released", home_req, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle();
    t_ocp_latch();
    t_clear_xrst();
    t_clear_uvlo();
    t_clear_sleep();
    t_clear_wins();
    t_tsd();
    t_uvlo();
    t_out_off();
    t_sleep();
    t_xrst();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule